// File: doc/BRIEF.md
# Double-Buffered PWM Waveform Generator

This block drives a single rectangular waveform. Its period and its high time are both counted in system clock cycles. Software-side logic presents new period and high-time values on two data inputs, each with its own one-cycle load strobe. A load only writes a staging register. The counter works from a separate active copy, and that copy is refreshed from staging only when a period ends or generation starts. As a result, every period that has begun runs to its full length with the settings it started with.

A run input controls generation. While run is high the waveform repeats with no further action. While run is low the output rests high and the counter waits at zero. On the last cycle of every period the block raises a one-cycle wrap event, which a neighbouring interrupt block can use. Everything runs on one clock domain and uses only its rising edge. The reset is asynchronous and active low.

Top module: `pwm_gen`

## Requirements
- R1: A pulse on `period_load` or `high_load` writes `period_in` or `high_in` into the matching staging register. A load by itself changes neither output.
- R2: A running period lasts P cycles, where P is the active period. For the first H of those cycles `pwm_out` is 1, where H is the active high time. For the remaining P-H cycles it is 0. The values are legal when 2 <= P <= 2^32-2 and 1 <= H <= P-1.
- R3: A load that arrives while a period is running changes neither the length nor the high time of that period. The new values govern the periods that begin after it.
- R4: Suppose `run` is sampled 1 at an edge while the generator is stopped. From the next cycle the staged values become active, counting starts at zero and `pwm_out` is 1.
- R5: Suppose `run` is sampled 0 at an edge. From the next cycle `pwm_out` is 1 and `wrap_evt` is 0, and both stay so until a start.
- R6: `wrap_evt` is 1 for exactly one cycle, the last cycle of each period. It is 0 whenever the generator is stopped.
- R7: While `run` stays 1, periods follow one another back to back, each starting high in the cycle right after the wrap cycle.
- R8: During and after reset the generator is stopped, `pwm_out` is 1, `wrap_evt` is 0, and all staging and active values are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_in | input | 32 | Period value to stage, in cycles |
| period_load | input | 1 | One-cycle strobe that stages `period_in` |
| high_in | input | 32 | High-time value to stage, in cycles |
| high_load | input | 1 | One-cycle strobe that stages `high_in` |
| run | input | 1 | 1 = generate continuously, 0 = stop |
| pwm_out | output | 1 | Registered waveform output |
| wrap_evt | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
Both outputs come from registers that take their value from the next-state logic. A change to `run` sampled at an edge therefore appears on `pwm_out` and `wrap_evt` in the cycle right after that edge, with no added latency. A staged value first shows in the cycle after the wrap cycle. The bench drives every input two time units after a rising edge and samples on the falling edge, so each sample reflects the registers that edge produced. Period and high-time lengths are measured by counting falling-edge samples between wrap events. A behavioural model advanced on the same edges is compared against both outputs on every cycle.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
   localparam int unsigned NUM_FIELDS = 2;
   localparam int unsigned FLD_PERIOD = 0;
   localparam int unsigned FLD_HIGH   = 1;

   typedef enum logic [1:0] {
      STEP_IDLE  = 2'd0,
      STEP_START = 2'd1,
      STEP_WRAP  = 2'd2,
      STEP_COUNT = 2'd3
   } pwm_step_e;

   function automatic bit width_ok(int unsigned w);
      return (w >= 2) && (w <= 64);
   endfunction
endpackage

// File: rtl/pwm_stage_bank.sv
module pwm_stage_bank #(
   parameter int unsigned W = 32,
   parameter int unsigned N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        load,
   input  logic [N-1:0][W-1:0] din,
   output logic [N-1:0][W-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("pwm_stage_bank needs at least one field");
      end
      for (genvar i = 0; i < N; i++) begin : g_field
         logic [W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (load[i]) begin
               hold_q <= din[i];
            end
         end
         assign q[i] = hold_q;
      end
   endgenerate
endmodule

// File: rtl/pwm_cycle_core.sv
module pwm_cycle_core
   import pwm_gen_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] stg_period,
   input  logic [W-1:0] stg_high,
   output logic         running_q,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] act_period,
   output logic [W-1:0] act_high,
   output logic         nxt_running,
   output logic [W-1:0] nxt_cnt,
   output logic [W-1:0] nxt_period,
   output logic [W-1:0] nxt_high
);
   localparam logic [W-1:0] ONE = W'(1);

   pwm_step_e    step;
   logic         at_end;
   logic [W-1:0] last_idx;

   assign last_idx = act_period - ONE;
   assign at_end   = (cnt_q == last_idx);

   always_comb begin
      if (!run) begin
         step = STEP_IDLE;
      end else if (!running_q) begin
         step = STEP_START;
      end else if (at_end) begin
         step = STEP_WRAP;
      end else begin
         step = STEP_COUNT;
      end
   end

   always_comb begin
      nxt_running = running_q;
      nxt_cnt     = cnt_q;
      nxt_period  = act_period;
      nxt_high    = act_high;
      unique case (step)
         STEP_IDLE: begin
            nxt_running = 1'b0;
            nxt_cnt     = '0;
         end
         STEP_START, STEP_WRAP: begin
            nxt_running = 1'b1;
            nxt_cnt     = '0;
            nxt_period  = stg_period;
            nxt_high    = stg_high;
         end
         STEP_COUNT: begin
            nxt_cnt = cnt_q + ONE;
         end
         default: begin
            nxt_running = 1'b0;
            nxt_cnt     = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q  <= 1'b0;
         cnt_q      <= '0;
         act_period <= '0;
         act_high   <= '0;
      end else begin
         running_q  <= nxt_running;
         cnt_q      <= nxt_cnt;
         act_period <= nxt_period;
         act_high   <= nxt_high;
      end
   end
endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         nxt_running,
   input  logic [W-1:0] nxt_cnt,
   input  logic [W-1:0] nxt_period,
   input  logic [W-1:0] nxt_high,
   output logic         pwm_q,
   output logic         wrap_q
);
   logic         lvl_d;
   logic         wrap_d;
   logic [W-1:0] end_idx;

   assign end_idx = nxt_period - W'(1);

   always_comb begin
      if (nxt_running) begin
         lvl_d  = (nxt_cnt < nxt_high);
         wrap_d = (nxt_cnt == end_idx);
      end else begin
         lvl_d  = 1'b1;
         wrap_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q  <= 1'b1;
         wrap_q <= 1'b0;
      end else begin
         pwm_q  <= lvl_d;
         wrap_q <= wrap_d;
      end
   end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
   import pwm_gen_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] period_in,
   input  logic         period_load,
   input  logic [W-1:0] high_in,
   input  logic         high_load,
   input  logic         run,
   output logic         pwm_out,
   output logic         wrap_evt
);
   generate
      if (!width_ok(W)) begin : g_bad_width
         $error("pwm_gen: W must lie between 2 and 64");
      end
   endgenerate

   logic [NUM_FIELDS-1:0]        stg_load;
   logic [NUM_FIELDS-1:0][W-1:0] stg_din;
   logic [NUM_FIELDS-1:0][W-1:0] stg_q;

   logic         running_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] act_period;
   logic [W-1:0] act_high;
   logic         nxt_running;
   logic [W-1:0] nxt_cnt;
   logic [W-1:0] nxt_period;
   logic [W-1:0] nxt_high;

   always_comb begin
      stg_load             = '0;
      stg_din              = '0;
      stg_load[FLD_PERIOD] = period_load;
      stg_load[FLD_HIGH]   = high_load;
      stg_din[FLD_PERIOD]  = period_in;
      stg_din[FLD_HIGH]    = high_in;
   end

   pwm_stage_bank #(.W(W), .N(NUM_FIELDS)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .load (stg_load),
      .din  (stg_din),
      .q    (stg_q)
   );

   pwm_cycle_core #(.W(W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .stg_period (stg_q[FLD_PERIOD]),
      .stg_high   (stg_q[FLD_HIGH]),
      .running_q  (running_q),
      .cnt_q      (cnt_q),
      .act_period (act_period),
      .act_high   (act_high),
      .nxt_running(nxt_running),
      .nxt_cnt    (nxt_cnt),
      .nxt_period (nxt_period),
      .nxt_high   (nxt_high)
   );

   pwm_wave_out #(.W(W)) u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .nxt_running(nxt_running),
      .nxt_cnt    (nxt_cnt),
      .nxt_period (nxt_period),
      .nxt_high   (nxt_high),
      .pwm_q      (pwm_out),
      .wrap_q     (wrap_evt)
   );
endmodule

// File: rtl/pwm_gen_checker.sv
module pwm_gen_checker #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run,
   input logic         pwm_out,
   input logic         wrap_evt,
   input logic         running,
   input logic [W-1:0] act_period,
   input logic [W-1:0] act_high,
   input logic [W-1:0] cnt
);
   // R5: a stop sampled at an edge drives the output high next cycle
   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pwm_out && !wrap_evt));

   // R6: the wrap event never lasts two cycles (period is at least 2)
   a_r6_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> !wrap_evt);

   // R2: the last cycle of a period is low, since high time is below period
   a_r2_low_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |-> !pwm_out);

   // R7: a new period starts high right after the wrap cycle
   a_r7_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_evt && run) |=> pwm_out);

   // R3: active settings hold while a period is in progress
   a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && run && !wrap_evt) |=> ($stable(act_period) && $stable(act_high)));

   // R2: the count stays inside the active period
   a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt < act_period));
endmodule

bind pwm_gen pwm_gen_checker #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .pwm_out   (pwm_out),
   .wrap_evt  (wrap_evt),
   .running   (running_q),
   .act_period(act_period),
   .act_high  (act_high),
   .cnt       (cnt_q)
);

// File: tb/test_pwm_gen.sv
`timescale 1ns/1ps
module test_pwm_gen;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] period_in = '0;
   logic         period_load = 1'b0;
   logic [W-1:0] high_in = '0;
   logic         high_load = 1'b0;
   logic         run = 1'b0;
   logic         pwm_out;
   logic         wrap_evt;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwm_gen #(.W(W)) i_pwm_gen (
      .clk(clk), .rst_n(rst_n),
      .period_in(period_in), .period_load(period_load),
      .high_in(high_in), .high_load(high_load),
      .run(run), .pwm_out(pwm_out), .wrap_evt(wrap_evt)
   );

   task automatic check(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit     m_on;
   longint m_cnt, m_p, m_h, s_p, s_h;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_on = 0; m_cnt = 0; m_p = 0; m_h = 0; s_p = 0; s_h = 0;
      end else begin
         if (!run) begin
            m_on = 0; m_cnt = 0;
         end else if (!m_on || m_cnt == m_p - 1) begin
            m_on = 1; m_cnt = 0; m_p = s_p; m_h = s_h;
         end else begin
            m_cnt++;
         end
         if (period_load) s_p = longint'(period_in);
         if (high_load)   s_h = longint'(high_in);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit ep, ew;
         ep = m_on ? (m_cnt < m_h) : 1'b1;
         ew = m_on && (m_cnt == m_p - 1);
         check(pwm_out == ep, m_on ? "R2 model level" : "R5 model idle", pwm_out, ep);
         check(wrap_evt == ew, "R6 model wrap", wrap_evt, ew);
      end
   end

   task automatic stage(longint p, longint h);
      @(posedge clk); #2;
      period_in = W'(p); high_in = W'(h);
      period_load = 1'b1; high_load = 1'b1;
      @(posedge clk); #2;
      period_load = 1'b0; high_load = 1'b0;
   endtask

   task automatic start_run();
      @(posedge clk); #2; run = 1'b1;
      @(negedge clk);
      check(pwm_out == 1'b1, "R4 still idle before start edge", pwm_out, 1);
   endtask

   task automatic measure(output int len, output int hi);
      len = 0; hi = 0;
      do begin
         @(negedge clk);
         len++;
         if (pwm_out) hi++;
      end while (!wrap_evt && len < 1000);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL R7 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int len, hi;
      repeat (3) @(negedge clk);
      check(pwm_out == 1'b1, "R8 reset output", pwm_out, 1);
      check(wrap_evt == 1'b0, "R8 reset wrap", wrap_evt, 0);
      @(posedge clk); #2; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pwm_out == 1'b1, "R8 after reset output", pwm_out, 1);

      stage(5, 2);
      repeat (3) @(negedge clk);
      check(pwm_out == 1'b1 && !wrap_evt, "R1 load leaves outputs", pwm_out, 1);

      start_run();
      measure(len, hi);
      check(len == 5, "R4 first period length", len, 5);
      check(hi == 2, "R4 first high time", hi, 2);
      for (int k = 0; k < 2; k++) begin
         measure(len, hi);
         check(len == 5 && hi == 2, "R7 repeat period", len * 100 + hi, 502);
      end

      stage(8, 3);
      measure(len, hi);
      check(len == 4 && hi == 1, "R3 running period untouched", len * 100 + hi, 401);
      measure(len, hi);
      check(len == 8 && hi == 3, "R3 new values next period", len * 100 + hi, 803);

      stage(2, 1);
      measure(len, hi);
      measure(len, hi);
      check(len == 2 && hi == 1, "R2 minimum period", len * 100 + hi, 201);
      measure(len, hi);
      check(len == 2 && hi == 1, "R6 wrap every second cycle", len * 100 + hi, 201);

      stage(7, 6);
      measure(len, hi);
      measure(len, hi);
      check(len == 7 && hi == 6, "R2 maximum high time", len * 100 + hi, 706);

      repeat (2) @(negedge clk);
      @(posedge clk); #2; run = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(pwm_out == 1'b1 && !wrap_evt, "R5 stopped high", pwm_out, 1);
      end

      stage(4, 1);
      start_run();
      measure(len, hi);
      check(len == 4 && hi == 1, "R4 restart with new stage", len * 100 + hi, 401);

      @(posedge clk); #2; run = 1'b0;
      stage(64'hFFFF_FFFE, 64'hFFFF_FFFD);
      start_run();
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         check(pwm_out == 1'b1 && !wrap_evt, "R2 large legal values high", pwm_out, 1);
      end
      @(posedge clk); #2; run = 1'b0;
      repeat (3) @(negedge clk);
      check(pwm_out == 1'b1, "R5 stop after large run", pwm_out, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule